// File: doc/BRIEF.md
# Masked Interrupt Status Controller

The block collects interrupt requests from peripherals into a 32-bit pending-status register and gates them with a 32-bit enable mask. Both registers sit on a simple register bus and accept 16-bit or 32-bit accesses. A single CPU interrupt line is raised whenever a pending bit is also enabled.

Software acknowledges interrupts by writing the status register. Each write keeps only the bits that are set in both the written value and the current mask, so a zero acknowledges and a masked bit is dropped. Two level-type sources, a serial port on bit 7 and a sound unit on bit 9, can be configured as always asserting. These bits are forced high just before the acknowledge is applied and are preset at reset. A DMA request has its own input and lands on bit 3. All other peripherals drive a generic request vector, which is sampled every clock.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, status reads 0x0000_0280 (bits 7 and 9 preset, with both hold parameters set), mask reads 0 and `irq_o` is 0.
- R2: Every bit set in `req_i` is set in status at the next clock edge and stays set until it is acknowledged. A status bit only rises because of a request or a forced hold bit.
- R3: A high `dma_req_i` sets status bit 3 at the next clock edge.
- R4: A 32-bit write to status offset 0x1070 loads status with (old status OR hold bits) AND mask AND written value.
- R5: Hold bits 7 and 9 are forced to 1 before the write AND, so they survive any status write whose value and mask both have them set.
- R6: A request arriving in the same cycle as an acknowledging write wins, and its bit ends up set.
- R7: A 16-bit write (`bus_wide_i`=0) to either register changes only bits 15:0 and leaves bits 31:16 unchanged.
- R8: A write to mask offset 0x1074 stores the written value unchanged.
- R9: A 32-bit read returns the whole register. A 16-bit read returns bits 15:0 with the upper half zero. Reads of other offsets return 0, and writes to other offsets change nothing.
- R10: `irq_o` is a register equal to OR(status AND mask). It updates at the same edge that commits a status or mask change, so a mask write that overlaps a pending bit raises it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr_i | input | 16 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| req_i | input | 32 | Level request per status bit |
| dma_req_i | input | 1 | DMA request, sets bit 3 |
| irq_o | output | 1 | CPU interrupt line |

## Verification
The bench checks that the acknowledge uses the mask as well as the data. A design that ANDed with the data only would keep masked bits alive after a write of all ones. It also checks that hold bit 9 comes back after a write that tries to clear it, and that a request arriving together with an acknowledge survives. A design that let the clear win would lose that event. Halfword writes are run against a mask with a nonzero upper half, which exposes a design that zeroes or overwrites bits 31:16. The bench also checks that `irq_o` changes on the edge of a mask write, not one cycle later.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  // Merge a write result: full width, or only the lower half.
  function automatic logic [31:0] half_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic wide);
    half_merge = wide ? new_v : {old_v[31:16], new_v[15:0]};
  endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_status_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] STAT_OFF = 16'h1070,
  parameter logic [AW-1:0] MASK_OFF = 16'h1074
) (
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o,
  output logic          wr_stat_o,
  output logic          wr_mask_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (en_i && addr_i == STAT_OFF) sel_o = SEL_STAT;
    else if (en_i && addr_i == MASK_OFF) sel_o = SEL_MASK;
  end

  assign wr_stat_o = we_i && (sel_o == SEL_STAT);
  assign wr_mask_o = we_i && (sel_o == SEL_MASK);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] HOLD_VEC = 32'h0000_0280
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          wide_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] req_i,
  output logic [DW-1:0] stat_d_o,
  output logic [DW-1:0] stat_q_o
);
  logic [DW-1:0] stat_q, acked, kept;

  // Hold sources re-asserted before the acknowledge AND.
  assign acked = (stat_q | HOLD_VEC) & mask_i & wdata_i;
  assign kept  = wr_i ? half_merge(stat_q, acked, wide_i) : stat_q;
  assign stat_d_o = kept | req_i;  // set beats clear

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= HOLD_VEC;
    else         stat_q <= stat_d_o;
  end

  assign stat_q_o = stat_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_status_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          wide_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_d_o,
  output logic [DW-1:0] mask_q_o
);
  logic [DW-1:0] mask_q;

  assign mask_d_o = wr_i ? half_merge(mask_q, wdata_i, wide_i) : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d_o;
  end

  assign mask_q_o = mask_q;
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] stat_d_i,
  input  logic [DW-1:0] mask_d_i,
  output logic          irq_o
);
  // Computed from next-state values so irq tracks the register edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_d_i & mask_d_i);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            DW          = 32,
  parameter logic [AW-1:0] STAT_OFF    = 16'h1070,
  parameter logic [AW-1:0] MASK_OFF    = 16'h1074,
  parameter int            DMA_BIT     = 3,
  parameter int            SER_BIT     = 7,
  parameter int            SND_BIT     = 9,
  parameter bit            SER_HOLD_EN = 1'b1,
  parameter bit            SND_HOLD_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_en_i,
  input  logic          bus_we_i,
  input  logic          bus_wide_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [DW-1:0] req_i,
  input  logic          dma_req_i,
  output logic          irq_o
);
  localparam int            HW       = DW / 2;
  localparam logic [DW-1:0] HOLD_VEC = (DW'(SER_HOLD_EN) << SER_BIT)
                                     | (DW'(SND_HOLD_EN) << SND_BIT);

  reg_sel_e      sel;
  logic          wr_stat, wr_mask;
  logic [DW-1:0] req_all, stat_d, stat_q, mask_d, mask_q, rd_full;

  assign req_all = req_i | (DW'(dma_req_i) << DMA_BIT);

  irq_bus_decode #(.AW(AW), .STAT_OFF(STAT_OFF), .MASK_OFF(MASK_OFF)) u_dec (
    .en_i(bus_en_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .sel_o(sel), .wr_stat_o(wr_stat), .wr_mask_o(wr_mask)
  );

  irq_status_reg #(.DW(DW), .HOLD_VEC(HOLD_VEC)) u_stat (
    .clk_i, .rst_ni, .wr_i(wr_stat), .wide_i(bus_wide_i),
    .wdata_i(bus_wdata_i), .mask_i(mask_q), .req_i(req_all),
    .stat_d_o(stat_d), .stat_q_o(stat_q)
  );

  irq_mask_reg #(.DW(DW)) u_mask (
    .clk_i, .rst_ni, .wr_i(wr_mask), .wide_i(bus_wide_i),
    .wdata_i(bus_wdata_i), .mask_d_o(mask_d), .mask_q_o(mask_q)
  );

  irq_out #(.DW(DW)) u_irq (
    .clk_i, .rst_ni, .stat_d_i(stat_d), .mask_d_i(mask_d), .irq_o(irq_o)
  );

  always_comb begin
    case (sel)
      SEL_STAT: rd_full = stat_q;
      SEL_MASK: rd_full = mask_q;
      default:  rd_full = '0;
    endcase
  end

  assign bus_rdata_o = bus_wide_i ? rd_full : {{(DW-HW){1'b0}}, rd_full[HW-1:0]};
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int            DW       = 32,
  parameter int            DMA_BIT  = 3,
  parameter logic [DW-1:0] HOLD_VEC = 32'h0000_0280,
  parameter logic [15:0]   STAT_OFF = 16'h1070,
  parameter logic [15:0]   MASK_OFF = 16'h1074
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_en_i,
  input logic          bus_we_i,
  input logic          bus_wide_i,
  input logic [15:0]   bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [DW-1:0] req_i,
  input logic          dma_req_i,
  input logic          irq_o,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_q
);
  logic [DW-1:0] req_all;
  logic          st_wr, mk_wr, any_wr;
  assign req_all = req_i | (DW'(dma_req_i) << DMA_BIT);
  assign st_wr   = bus_en_i && bus_we_i && bus_addr_i == STAT_OFF;
  assign mk_wr   = bus_en_i && bus_we_i && bus_addr_i == MASK_OFF;
  assign any_wr  = bus_en_i && bus_we_i;

  AST_REQ_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_all != '0) |=> ((stat_q & $past(req_all)) == $past(req_all))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(req_all) & ~HOLD_VEC) == '0)); // R2
  AST_DMA_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i |=> stat_q[DMA_BIT]); // R3
  AST_ACK_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && bus_wide_i && req_all == '0) |=>
      (stat_q == (($past(stat_q) | HOLD_VEC) & $past(mask_q) & $past(bus_wdata_i)))); // R4
  AST_HOLD_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && ((HOLD_VEC & mask_q & bus_wdata_i) == HOLD_VEC)) |=>
      ((stat_q & HOLD_VEC) == HOLD_VEC)); // R5
  AST_HALF_KEEPS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk_wr && !bus_wide_i) |=> (mask_q[DW-1:DW/2] == $past(mask_q[DW-1:DW/2]))); // R7
  AST_MASK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk_wr && bus_wide_i) |=> (mask_q == $past(bus_wdata_i))); // R8
  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mk_wr |=> $stable(mask_q)); // R9
  AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(stat_q & mask_q)); // R10
  AST_ANY_WR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |-> !$isunknown(bus_addr_i)); // R9
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .DW(DW), .DMA_BIT(DMA_BIT), .HOLD_VEC(HOLD_VEC),
  .STAT_OFF(STAT_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
  .bus_wide_i(bus_wide_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .req_i(req_i), .dma_req_i(dma_req_i), .irq_o(irq_o),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/100ps
module irq_status_ctrl_test;
  localparam logic [15:0] A_STAT  = 16'h1070;
  localparam logic [15:0] A_MASK  = 16'h1074;
  localparam logic [15:0] A_OTHER = 16'h1078;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_en = 0, bus_we = 0, bus_wide = 1;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, req = '0;
  logic        dma_req = 0, irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_status_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_wide_i(bus_wide), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .req_i(req), .dma_req_i(dma_req), .irq_o(irq)
  );

  // op: 0 idle, 1 status write, 2 mask write, 3 write to unmapped offset
  typedef struct packed {
    logic [1:0]  op;
    logic        wide;
    logic [31:0] data;
    logic [31:0] rq;
    logic        dma;
    logic [31:0] e_stat;
    logic [31:0] e_mask;
    logic        e_irq;
    logic [7:0]  rtag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b1, 32'hABCD_0208, 32'h0,        1'b0, 32'h0000_0280, 32'hABCD_0208, 1'b1, 8'd8},  // R8
    '{2'd0, 1'b1, 32'h0,         32'h1,        1'b0, 32'h0000_0281, 32'hABCD_0208, 1'b1, 8'd2},  // R2
    '{2'd1, 1'b1, 32'hFFFF_FFFF, 32'h0,        1'b0, 32'h0000_0200, 32'hABCD_0208, 1'b1, 8'd4},  // R4
    '{2'd1, 1'b1, 32'h0,         32'h0,        1'b0, 32'h0000_0000, 32'hABCD_0208, 1'b0, 8'd4},  // R4
    '{2'd0, 1'b1, 32'h0,         32'h0,        1'b1, 32'h0000_0008, 32'hABCD_0208, 1'b1, 8'd3},  // R3
    '{2'd1, 1'b1, 32'h8,         32'h10,       1'b0, 32'h0000_0018, 32'hABCD_0208, 1'b1, 8'd6},  // R6
    '{2'd1, 1'b1, 32'hFFFF_FFF7, 32'h0,        1'b0, 32'h0000_0200, 32'hABCD_0208, 1'b1, 8'd5},  // R5
    '{2'd2, 1'b0, 32'h0000_1234, 32'h0,        1'b0, 32'h0000_0200, 32'hABCD_1234, 1'b1, 8'd7},  // R7
    '{2'd2, 1'b1, 32'hFFFF_0000, 32'h0,        1'b0, 32'h0000_0200, 32'hFFFF_0000, 1'b0, 8'd10}, // R10
    '{2'd0, 1'b1, 32'h0,         32'h0001_0000,1'b0, 32'h0001_0200, 32'hFFFF_0000, 1'b1, 8'd2},  // R2
    '{2'd1, 1'b0, 32'h0,         32'h0,        1'b0, 32'h0001_0000, 32'hFFFF_0000, 1'b1, 8'd7},  // R7
    '{2'd2, 1'b0, 32'h0000_00FF, 32'h0,        1'b0, 32'h0001_0000, 32'hFFFF_00FF, 1'b1, 8'd7},  // R7
    '{2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0,        1'b0, 32'h0001_0000, 32'hFFFF_00FF, 1'b1, 8'd9},  // R9
    '{2'd1, 1'b1, 32'hFFFF_FFFF, 32'h0,        1'b0, 32'h0001_0080, 32'hFFFF_00FF, 1'b1, 8'd5}   // R5
  };

  task automatic check(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic w, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_wide = w;
    #0.5 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    // R1: reset state
    #10;
    rd(A_STAT, 1, d); check("reset status", 1, d, 32'h0000_0280);
    rd(A_MASK, 1, d); check("reset mask", 1, d, 32'h0);
    check("reset irq", 1, {31'b0, irq}, 32'h0);
    @(negedge clk); rst_ni = 1;

    foreach (VECS[i]) begin
      @(negedge clk);
      bus_en    = VECS[i].op != 2'd0;
      bus_we    = VECS[i].op != 2'd0;
      bus_wide  = VECS[i].wide;
      bus_wdata = VECS[i].data;
      bus_addr  = VECS[i].op == 2'd1 ? A_STAT : VECS[i].op == 2'd2 ? A_MASK : A_OTHER;
      req       = VECS[i].rq;
      dma_req   = VECS[i].dma;
      @(negedge clk);
      bus_en = 0; bus_we = 0; req = '0; dma_req = 0;
      rd(A_STAT, 1, d); check($sformatf("vec %0d status", i), int'(VECS[i].rtag), d, VECS[i].e_stat);
      rd(A_MASK, 1, d); check($sformatf("vec %0d mask", i), int'(VECS[i].rtag), d, VECS[i].e_mask);
      check($sformatf("vec %0d irq", i), 10, {31'b0, irq}, {31'b0, VECS[i].e_irq});
    end

    // R9: halfword read and unmapped read
    rd(A_STAT, 0, d);  check("16-bit status read", 9, d, 32'h0000_0080);
    rd(A_MASK, 0, d);  check("16-bit mask read", 9, d, 32'h0000_00FF);
    rd(A_OTHER, 1, d); check("unmapped read", 9, d, 32'h0);

    // R10: irq changes at the committing edge, not before
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_wide = 1; bus_addr = A_MASK; bus_wdata = 32'h0;
    #1 check("irq before mask edge", 10, {31'b0, irq}, 32'h1);
    @(negedge clk); bus_en = 0; bus_we = 0;
    check("irq after mask clear", 10, {31'b0, irq}, 32'h0);

    // R1: asynchronous reset mid-run
    #1 rst_ni = 0;
    #0.5;
    rd(A_STAT, 1, d); check("re-reset status", 1, d, 32'h0000_0280);
    rd(A_MASK, 1, d); check("re-reset mask", 1, d, 32'h0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    finish_run();
  end
endmodule